// File: doc/BRIEF.md
# Hierarchical Interrupt Status Unit

This block gathers interrupt causes for a transmit engine that runs many queues. Each queue raises its own event pulses. Those pulses land in five secondary status words, and a single primary word gives software a compact view of them. Most primary bits are not stored. Each such bit is the OR of one group of secondary bits. Two primary bits, no-frame and beacon-not-ready, latch directly from their own event inputs.

Software clears causes by writing ones. A write to a secondary word clears only the bits written as one. A write to a primary summary bit clears its whole group of secondary bits. A second primary address clears on read. One read of it returns the primary value, copies every secondary word into a read-only shadow, and clears all status in the same clock edge. An event that arrives in the same cycle as any clear always survives it. A mask selects which primary bits drive the registered interrupt line.

Top module: `irq_status_unit`

## Requirements
- R1: After reset every status word, every shadow, the mask and `irq_o` are zero.
- R2: Event pulses set secondary bits on the next edge, with queue q at bit q of the low field or bit 16+q of the high field. The fields are: word 0 low successful-transmit, word 0 high descriptor-request, word 1 low transmit-error, word 1 high end-of-list, word 2 low underrun, word 3 low CBR-overrun, word 3 high CBR-underrun, and word 4 low queue-trigger. In word 2, host error n sits at bit 16+n and beacon cause n at bit 24+n.
- R3: Each primary summary bit reads as the OR of its secondary group: successful-transmit 6, descriptor-request 7, transmit-error 8, end-of-list 10, underrun 11, host-error 19, misc-beacon 23, CBR-overrun 25, CBR-underrun 26, queue-trigger 27.
- R4: The no-frame event latches primary bit 9 and the beacon-not-ready event latches primary bit 20.
- R5: Writing a secondary word (addresses 2 to 6 for words 0 to 4) clears exactly the bits written as one and keeps every other bit.
- R6: Writing the primary word (address 0) with a summary bit at one clears that bit's whole secondary group. A one at bit 9 or bit 20 clears that latched bit. Other primary bits have no effect.
- R7: An event arriving in the same cycle as a clear of its bit leaves the bit set.
- R8: A read of address 1 returns the primary value, copies secondary words 0 to 4 into shadows at addresses 7 to 11, and clears all status on that edge.
- R9: Shadows ignore writes. Reads of any address other than 1 change no state. Writes to address 1 are ignored.
- R10: Bits outside the defined fields read zero and cannot be set by writes. Addresses 13 to 15 read zero.
- R11: `irq_o` is the OR of the primary word ANDed with the mask. It follows a status change one clock later.
- R12: The mask at address 12 is a full 32-bit read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Combinational read data |
| ev_txok | input | NQ | Per-queue successful-transmit events |
| ev_txdesc | input | NQ | Per-queue descriptor-request events |
| ev_txerr | input | NQ | Per-queue transmit-error events |
| ev_eol | input | NQ | Per-queue end-of-list events |
| ev_urn | input | NQ | Per-queue underrun events |
| ev_cbro | input | NQ | Per-queue CBR-overrun events |
| ev_cbru | input | NQ | Per-queue CBR-underrun events |
| ev_qtrig | input | NQ | Per-queue trigger events |
| ev_hif | input | 3 | Host interface errors (abort, system, parity) |
| ev_bcn | input | 6 | Beacon causes (TIM, CAB end, DTIM sync, beacon timeout, CAB timeout, DTIM) |
| ev_nofrm | input | 1 | No-frame event |
| ev_bnr | input | 1 | Beacon-not-ready event |
| irq_o | output | 1 | Masked interrupt request |

## Verification
A corrupted secondary bit appears on the primary summary and on the interrupt line within one read or one clock. A clear that reaches too far removes a neighbouring cause, which the next read of that secondary word exposes at once. The most delicate case is a clear racing an event, so the bench lines up events with secondary writes, primary writes and clear-on-read in the same cycle. It then reads the words back on the following cycle. A shadow that snapshots late would hold the racing event, so the shadows are compared against the value captured before the edge.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;

    localparam int REG_W   = 32;
    localparam int NUM_SEC = 5;
    localparam int ADDR_W  = 4;
    localparam int HI_LSB  = 16;

    // primary bit positions
    localparam int PB_TXOK  = 6;
    localparam int PB_DESC  = 7;
    localparam int PB_TXERR = 8;
    localparam int PB_NOFRM = 9;
    localparam int PB_EOL   = 10;
    localparam int PB_URN   = 11;
    localparam int PB_HIF   = 19;
    localparam int PB_BNR   = 20;
    localparam int PB_BCN   = 23;
    localparam int PB_CBRO  = 25;
    localparam int PB_CBRU  = 26;
    localparam int PB_QTRIG = 27;

    // extra fields in secondary word 2
    localparam int HIF_LSB = 16;
    localparam int HIF_N   = 3;
    localparam int BCN_LSB = 24;
    localparam int BCN_N   = 6;

    // summary groups, in order of the group-clear vector
    localparam int G_TXOK  = 0;
    localparam int G_DESC  = 1;
    localparam int G_TXERR = 2;
    localparam int G_EOL   = 3;
    localparam int G_URN   = 4;
    localparam int G_HIF   = 5;
    localparam int G_BCN   = 6;
    localparam int G_CBRO  = 7;
    localparam int G_CBRU  = 8;
    localparam int G_QTRIG = 9;
    localparam int NUM_GRP = 10;

    // word addresses
    localparam logic [ADDR_W-1:0] A_PRIM = 4'd0;
    localparam logic [ADDR_W-1:0] A_RAC  = 4'd1;
    localparam int                A_SEC0 = 2;
    localparam int                A_SHD0 = 7;
    localparam logic [ADDR_W-1:0] A_MASK = 4'd12;

    function automatic logic [REG_W-1:0] span(input int lsb, input int n);
        logic [REG_W-1:0] m;
        m = '0;
        for (int b = 0; b < REG_W; b++) begin
            if (b >= lsb && b < lsb + n) m[b] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [REG_W-1:0] sec_valid(input int idx, input int nq);
        logic [REG_W-1:0] m;
        case (idx)
            2:       m = span(0, nq) | span(HIF_LSB, HIF_N) | span(BCN_LSB, BCN_N);
            4:       m = span(0, nq);
            default: m = span(0, nq) | span(HI_LSB, nq);
        endcase
        return m;
    endfunction

endpackage

// File: rtl/irq_sec_reg.sv
module irq_sec_reg
    import irq_stat_pkg::*;
#(
    parameter logic [REG_W-1:0] VALID = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] set_i,
    input  logic [REG_W-1:0] clr_i,
    input  logic             snap_i,
    output logic [REG_W-1:0] stat_o,
    output logic [REG_W-1:0] shadow_o
);

    logic [REG_W-1:0] stat_q;
    logic [REG_W-1:0] shadow_q;
    logic [REG_W-1:0] stat_d;

    // set wins over any clear in the same cycle
    always_comb begin
        stat_d = stat_q & ~clr_i;
        if (snap_i) stat_d = '0;
        stat_d = (stat_d | set_i) & VALID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q   <= '0;
            shadow_q <= '0;
        end else begin
            stat_q <= stat_d;
            if (snap_i) shadow_q <= stat_q;
        end
    end

    assign stat_o   = stat_q;
    assign shadow_o = shadow_q;

endmodule

// File: rtl/irq_prim_map.sv
module irq_prim_map
    import irq_stat_pkg::*;
#(
    parameter int NQ = 10
) (
    input  logic [NUM_SEC-1:0][REG_W-1:0] sec_i,
    input  logic [1:0]                    dir_i,
    input  logic [NUM_GRP-1:0]            grp_clr_i,
    output logic [REG_W-1:0]              prim_o,
    output logic [NUM_SEC-1:0][REG_W-1:0] sec_clr_o
);

    localparam logic [REG_W-1:0] LO  = span(0, NQ);
    localparam logic [REG_W-1:0] HI  = span(HI_LSB, NQ);
    localparam logic [REG_W-1:0] HIF = span(HIF_LSB, HIF_N);
    localparam logic [REG_W-1:0] BCN = span(BCN_LSB, BCN_N);

    always_comb begin
        prim_o           = '0;
        prim_o[PB_TXOK]  = |(sec_i[0] & LO);
        prim_o[PB_DESC]  = |(sec_i[0] & HI);
        prim_o[PB_TXERR] = |(sec_i[1] & LO);
        prim_o[PB_EOL]   = |(sec_i[1] & HI);
        prim_o[PB_URN]   = |(sec_i[2] & LO);
        prim_o[PB_HIF]   = |(sec_i[2] & HIF);
        prim_o[PB_BCN]   = |(sec_i[2] & BCN);
        prim_o[PB_CBRO]  = |(sec_i[3] & LO);
        prim_o[PB_CBRU]  = |(sec_i[3] & HI);
        prim_o[PB_QTRIG] = |(sec_i[4] & LO);
        prim_o[PB_NOFRM] = dir_i[0];
        prim_o[PB_BNR]   = dir_i[1];
    end

    always_comb begin
        sec_clr_o    = '0;
        sec_clr_o[0] = (grp_clr_i[G_TXOK]  ? LO  : '0) | (grp_clr_i[G_DESC] ? HI : '0);
        sec_clr_o[1] = (grp_clr_i[G_TXERR] ? LO  : '0) | (grp_clr_i[G_EOL]  ? HI : '0);
        sec_clr_o[2] = (grp_clr_i[G_URN]   ? LO  : '0) | (grp_clr_i[G_HIF]  ? HIF : '0)
                     | (grp_clr_i[G_BCN]   ? BCN : '0);
        sec_clr_o[3] = (grp_clr_i[G_CBRO]  ? LO  : '0) | (grp_clr_i[G_CBRU] ? HI : '0);
        sec_clr_o[4] = (grp_clr_i[G_QTRIG] ? LO  : '0);
    end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
    import irq_stat_pkg::*;
#(
    parameter int NQ = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    input  logic              bus_rd,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [NQ-1:0]     ev_txok,
    input  logic [NQ-1:0]     ev_txdesc,
    input  logic [NQ-1:0]     ev_txerr,
    input  logic [NQ-1:0]     ev_eol,
    input  logic [NQ-1:0]     ev_urn,
    input  logic [NQ-1:0]     ev_cbro,
    input  logic [NQ-1:0]     ev_cbru,
    input  logic [NQ-1:0]     ev_qtrig,
    input  logic [HIF_N-1:0]  ev_hif,
    input  logic [BCN_N-1:0]  ev_bcn,
    input  logic              ev_nofrm,
    input  logic              ev_bnr,
    output logic              irq_o
);

    logic [NUM_SEC-1:0][REG_W-1:0] sec_q;
    logic [NUM_SEC-1:0][REG_W-1:0] shd_q;
    logic [NUM_SEC-1:0][REG_W-1:0] sec_set;
    logic [NUM_SEC-1:0][REG_W-1:0] prim_clr;
    logic [REG_W-1:0]              prim;
    logic [NUM_GRP-1:0]            grp_clr;
    logic [1:0]                    dir_q;
    logic [1:0]                    dir_clr;
    logic [REG_W-1:0]              mask_q;
    logic                          irq_q;
    logic                          rac_rd;
    logic                          prim_wr;

    assign rac_rd  = bus_rd && (bus_addr == A_RAC);
    assign prim_wr = bus_wr && (bus_addr == A_PRIM);

    // event placement into secondary words
    always_comb begin
        sec_set                      = '0;
        sec_set[0][NQ-1:0]           = ev_txok;
        sec_set[0][HI_LSB +: NQ]     = ev_txdesc;
        sec_set[1][NQ-1:0]           = ev_txerr;
        sec_set[1][HI_LSB +: NQ]     = ev_eol;
        sec_set[2][NQ-1:0]           = ev_urn;
        sec_set[2][HIF_LSB +: HIF_N] = ev_hif;
        sec_set[2][BCN_LSB +: BCN_N] = ev_bcn;
        sec_set[3][NQ-1:0]           = ev_cbro;
        sec_set[3][HI_LSB +: NQ]     = ev_cbru;
        sec_set[4][NQ-1:0]           = ev_qtrig;
    end

    // primary write: summary bits expand to group clears
    always_comb begin
        grp_clr          = '0;
        dir_clr          = '0;
        if (prim_wr) begin
            grp_clr[G_TXOK]  = bus_wdata[PB_TXOK];
            grp_clr[G_DESC]  = bus_wdata[PB_DESC];
            grp_clr[G_TXERR] = bus_wdata[PB_TXERR];
            grp_clr[G_EOL]   = bus_wdata[PB_EOL];
            grp_clr[G_URN]   = bus_wdata[PB_URN];
            grp_clr[G_HIF]   = bus_wdata[PB_HIF];
            grp_clr[G_BCN]   = bus_wdata[PB_BCN];
            grp_clr[G_CBRO]  = bus_wdata[PB_CBRO];
            grp_clr[G_CBRU]  = bus_wdata[PB_CBRU];
            grp_clr[G_QTRIG] = bus_wdata[PB_QTRIG];
            dir_clr          = {bus_wdata[PB_BNR], bus_wdata[PB_NOFRM]};
        end
    end

    irq_prim_map #(.NQ(NQ)) u_map (
        .sec_i     (sec_q),
        .dir_i     (dir_q),
        .grp_clr_i (grp_clr),
        .prim_o    (prim),
        .sec_clr_o (prim_clr)
    );

    for (genvar i = 0; i < NUM_SEC; i++) begin : g_sec
        localparam logic [ADDR_W-1:0] SEC_ADDR = ADDR_W'(A_SEC0 + i);
        logic [REG_W-1:0] clr;
        assign clr = ((bus_wr && bus_addr == SEC_ADDR) ? bus_wdata : '0) | prim_clr[i];
        irq_sec_reg #(.VALID(sec_valid(i, NQ))) u_reg (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (sec_set[i]),
            .clr_i    (clr),
            .snap_i   (rac_rd),
            .stat_o   (sec_q[i]),
            .shadow_o (shd_q[i])
        );
    end

    // directly latched primary bits, mask and interrupt line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            dir_q <= (rac_rd ? 2'b00 : (dir_q & ~dir_clr)) | {ev_bnr, ev_nofrm};
            if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata;
            irq_q <= |(prim & mask_q);
        end
    end

    assign irq_o = irq_q;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_PRIM || bus_addr == A_RAC) begin
            bus_rdata = prim;
        end else if (bus_addr == A_MASK) begin
            bus_rdata = mask_q;
        end else begin
            for (int i = 0; i < NUM_SEC; i++) begin
                if (bus_addr == ADDR_W'(A_SEC0 + i)) bus_rdata = sec_q[i];
                if (bus_addr == ADDR_W'(A_SHD0 + i)) bus_rdata = shd_q[i];
            end
        end
    end

endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
    import irq_stat_pkg::*;
#(
    parameter int NQ = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [REG_W-1:0]  bus_wdata,
    input logic              bus_rd,
    input logic [REG_W-1:0]  bus_rdata,
    input logic [NQ-1:0]     ev_txok,
    input logic [NQ-1:0]     ev_txdesc,
    input logic [REG_W-1:0]  sec0,
    input logic [REG_W-1:0]  shd0,
    input logic [REG_W-1:0]  mask,
    input logic              irq
);

    // R7
    ev_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_txok != '0) |=> ((sec0[NQ-1:0] & $past(ev_txok)) == $past(ev_txok)));

    // R5
    w1c_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(A_SEC0))
        |=> ((sec0 & $past(sec0 & ~bus_wdata)) == $past(sec0 & ~bus_wdata)));

    // R8
    rac_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_RAC) |=> (shd0 == $past(sec0)));

    // R8
    rac_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_RAC && ev_txok == '0 && ev_txdesc == '0) |=> (sec0 == '0));

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_addr == A_RAC) |=> $stable(shd0));

    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0 && !(bus_wr && bus_addr == A_MASK)) |=> !irq);

    // R10
    unused_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > A_MASK) |-> (bus_rdata == '0));

endmodule

bind irq_status_unit irq_status_chk #(.NQ(NQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .ev_txok   (ev_txok),
    .ev_txdesc (ev_txdesc),
    .sec0      (sec_q[0]),
    .shd0      (shd_q[0]),
    .mask      (mask_q),
    .irq       (irq_q)
);

// File: tb/sim_irq_status_unit.sv
`timescale 1ns/1ps
module sim_irq_status_unit;

    localparam int NQ = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [NQ-1:0] ev_txok = '0, ev_txdesc = '0, ev_txerr = '0, ev_eol = '0;
    logic [NQ-1:0] ev_urn = '0, ev_cbro = '0, ev_cbru = '0, ev_qtrig = '0;
    logic [2:0]  ev_hif = '0;
    logic [5:0]  ev_bcn = '0;
    logic        ev_nofrm = 1'b0, ev_bnr = 1'b0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_status_unit #(.NQ(NQ)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ev_clear();
        ev_txok = '0; ev_txdesc = '0; ev_txerr = '0; ev_eol = '0;
        ev_urn = '0; ev_cbro = '0; ev_cbru = '0; ev_qtrig = '0;
        ev_hif = '0; ev_bcn = '0; ev_nofrm = 1'b0; ev_bnr = 1'b0;
    endtask

    task automatic ev_step();
        @(negedge clk);
        ev_clear();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        ev_clear();
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        ev_clear();
    endtask

    task automatic clear_all();
        logic [31:0] d;
        rd(4'd1, d);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd0, d);  chk("R1 primary", d, 0);
        rd(4'd2, d);  chk("R1 sec0", d, 0);
        rd(4'd7, d);  chk("R1 shadow0", d, 0);
        rd(4'd12, d); chk("R1 mask", d, 0);
        chk("R1 irq", {31'd0, irq_o}, 0);
    endtask

    task automatic t_events();
        logic [31:0] d;
        clear_all();
        ev_txok = 10'h008; ev_txdesc = 10'h020; ev_eol = 10'h200;
        ev_urn = 10'h001; ev_hif = 3'b010; ev_bcn = 6'b001000;
        ev_cbro = 10'h004; ev_cbru = 10'h002; ev_qtrig = 10'h010;
        ev_step();
        rd(4'd2, d); chk("R2 sec0", d, (32'h1 << 3) | (32'h1 << 21));
        rd(4'd3, d); chk("R2 sec1", d, 32'h1 << 25);
        rd(4'd4, d); chk("R2 sec2", d, 32'h1 | (32'h1 << 17) | (32'h1 << 27));
        rd(4'd5, d); chk("R2 sec3", d, (32'h1 << 2) | (32'h1 << 17));
        rd(4'd6, d); chk("R2 sec4", d, 32'h1 << 4);
        rd(4'd0, d);
        chk("R3 primary", d, (32'h1 << 6) | (32'h1 << 7) | (32'h1 << 10) | (32'h1 << 11)
            | (32'h1 << 19) | (32'h1 << 23) | (32'h1 << 25) | (32'h1 << 26) | (32'h1 << 27));
    endtask

    task automatic t_direct();
        logic [31:0] d;
        clear_all();
        ev_nofrm = 1'b1; ev_step();
        rd(4'd0, d); chk("R4 no-frame", d, 32'h1 << 9);
        ev_bnr = 1'b1; ev_step();
        rd(4'd0, d); chk("R4 beacon-not-ready", d, (32'h1 << 9) | (32'h1 << 20));
    endtask

    task automatic t_w1c_sec();
        logic [31:0] d;
        clear_all();
        ev_txok = 10'h008; ev_txdesc = 10'h020; ev_step();
        wr(4'd2, 32'h1 << 3);
        rd(4'd2, d); chk("R5 sec0 partial clear", d, 32'h1 << 21);
        rd(4'd0, d); chk("R5 primary after clear", d, 32'h1 << 7);
    endtask

    task automatic t_w1c_prim();
        logic [31:0] d;
        clear_all();
        ev_txok = 10'h009; ev_txdesc = 10'h020; ev_txerr = 10'h004; ev_nofrm = 1'b1;
        ev_step();
        wr(4'd0, 32'h1 << 6);
        rd(4'd2, d); chk("R6 group clear sec0", d, 32'h1 << 21);
        rd(4'd3, d); chk("R6 other word kept", d, 32'h1 << 2);
        wr(4'd0, 32'h1);
        rd(4'd0, d); chk("R6 inert primary bit", d, (32'h1 << 7) | (32'h1 << 8) | (32'h1 << 9));
        wr(4'd0, 32'h1 << 9);
        rd(4'd0, d); chk("R6 direct clear", d, (32'h1 << 7) | (32'h1 << 8));
    endtask

    task automatic t_collide();
        logic [31:0] d;
        clear_all();
        ev_txok = 10'h002; ev_step();
        ev_txok = 10'h002; wr(4'd2, 32'h2);
        rd(4'd2, d); chk("R7 event beats sec write", d, 32'h2);
        ev_txok = 10'h010; wr(4'd0, 32'h1 << 6);
        rd(4'd2, d); chk("R7 event beats group clear", d, 32'h10);
    endtask

    task automatic t_rac();
        logic [31:0] d;
        clear_all();
        ev_txok = 10'h008; ev_bcn = 6'b000001; ev_nofrm = 1'b1; ev_step();
        ev_qtrig = 10'h002;
        rd(4'd1, d); chk("R8 returns primary", d, (32'h1 << 6) | (32'h1 << 9) | (32'h1 << 23));
        rd(4'd2, d); chk("R8 sec0 cleared", d, 0);
        rd(4'd6, d); chk("R8 racing event kept", d, 32'h2);
        rd(4'd0, d); chk("R8 primary after", d, 32'h1 << 27);
        rd(4'd7, d); chk("R8 shadow0", d, 32'h1 << 3);
        rd(4'd9, d); chk("R8 shadow2", d, 32'h1 << 24);
        rd(4'd11, d); chk("R8 shadow4", d, 0);
    endtask

    task automatic t_shadow_ro();
        logic [31:0] d;
        wr(4'd7, 32'hFFFF_FFFF);
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd7, d); chk("R9 shadow ignores write", d, 32'h1 << 3);
        rd(4'd0, d); rd(4'd0, d); chk("R9 plain read keeps state", d, 32'h1 << 27);
        rd(4'd6, d); chk("R9 sec read keeps state", d, 32'h2);
    endtask

    task automatic t_unused();
        logic [31:0] d;
        clear_all();
        wr(4'd2, 32'hFFFF_FFFF);
        rd(4'd2, d); chk("R10 write cannot set", d, 0);
        wr(4'd14, 32'hFFFF_FFFF);
        rd(4'd14, d); chk("R10 hole reads zero", d, 0);
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd12, d); chk("R12 mask all ones", d, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        clear_all();
        wr(4'd12, 32'h1 << 7);
        rd(4'd12, d); chk("R12 mask readback", d, 32'h1 << 7);
        ev_txok = 10'h001; ev_step();
        @(negedge clk); chk("R11 masked cause", {31'd0, irq_o}, 0);
        ev_txdesc = 10'h001; ev_step();
        chk("R11 one cycle later still low", {31'd0, irq_o}, 0);
        @(negedge clk); chk("R11 raised", {31'd0, irq_o}, 1);
        wr(4'd2, 32'h1 << 16);
        chk("R11 drop lags one cycle", {31'd0, irq_o}, 1);
        @(negedge clk); chk("R11 dropped", {31'd0, irq_o}, 0);
        wr(4'd12, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_direct();
        t_w1c_sec();
        t_w1c_prim();
        t_collide();
        t_rac();
        t_shadow_ro();
        t_unused();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule